// File: doc/BRIEF.md
# Register-Block Word Store Sequencer

This block carries out a store-multiple-word operation for a processor's load/store pipe. A single command names a starting register, a base register field with its value, a 16-bit signed displacement and the current byte-order mode. The block then walks the general-purpose registers from the starting one up to the highest register. For each register it drives the register index on a read port and takes the low word from the returned value. It offers that word as one memory write on a valid/ready channel, at consecutive word addresses beginning at the computed effective address.

The effective address uses zero as the base when the base register field is zero; otherwise it uses the supplied base value. The displacement is sign-extended and added to that base. The operation is not defined in little-endian mode. In that mode the block writes nothing and raises a one-cycle alignment-exception request. The pipe sees `busy` for the whole operation and a one-cycle `done` pulse after the last word is accepted.

Top module: `reg_block_store_seq`

## Requirements
- R1: The first write address equals the base (zero when `cmd_base_sel` is 0, otherwise `cmd_base_val`) plus `cmd_disp` sign-extended to XLEN bits, modulo 2^XLEN.
- R2: A command with starting register s produces exactly 32 − s writes, for registers s, s+1, …, 31 in ascending order, and `rf_rd_idx` carries the register whose word is being offered.
- R3: Each written word `mem_wdata` equals the low 32-bit word returned on `rf_rd_data` for the register being offered.
- R4: Each accepted write that is not the last is followed by a write at the previous address plus 4, modulo 2^XLEN.
- R5: While `mem_wvalid` is high and `mem_wready` is low, the next cycle keeps `mem_wvalid` high with `mem_waddr` and `rf_rd_idx` unchanged.
- R6: `done` is high for exactly one cycle, in the cycle after the write from register 31 is accepted, and `busy` is low in the following cycle. A starting register of 31 gives exactly one write.
- R7: A command accepted with `cmd_little_endian` = 1 makes no write. `align_exc` is high for one cycle in the cycle after acceptance, and `busy` is low the cycle after that.
- R8: `busy` rises in the cycle after a command is accepted and stays high until the `done` or `align_exc` cycle. A command presented while `busy` is high changes neither the write stream nor its addresses.
- R9: After reset, `busy`, `mem_wvalid`, `done` and `align_exc` are low.
- R10: At most one of `mem_wvalid`, `done` and `align_exc` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when `busy` is low |
| cmd_start_reg | input | 5 | First register to store |
| cmd_base_sel | input | 5 | Base register field; 0 selects a zero base |
| cmd_base_val | input | XLEN (64) | Value of the base register |
| cmd_disp | input | 16 | Signed displacement |
| cmd_little_endian | input | 1 | 1 = little-endian mode (operation refused) |
| rf_rd_idx | output | 5 | Register read index |
| rf_rd_data | input | 32 | Low word of the indexed register (combinational read) |
| mem_wvalid | output | 1 | Write request valid |
| mem_waddr | output | XLEN (64) | Write byte address |
| mem_wdata | output | 32 | Write data word |
| mem_wready | input | 1 | Write accepted when high with `mem_wvalid` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| align_exc | output | 1 | One-cycle alignment-exception request |

## Verification
A command taken at a clock edge shows its first write, or its exception pulse, in the very next cycle. Each accepted write shows its successor in the cycle after. `done` follows the final acceptance by one cycle, and `busy` drops one cycle after that. The bench drives inputs and samples outputs on the falling edge. Between those samples exactly one rising edge occurs, so each check compares against the expectation for the cycle that edge produces. Write acceptance is randomised per cycle to create stalls, and a junk command is presented in the first busy cycle.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PUSH  = 2'd1,
    ST_FIN   = 2'd2,
    ST_FAULT = 2'd3
  } rbs_state_e;
endpackage

// File: rtl/rbs_addr_gen.sv
module rbs_addr_gen #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int SEL_W  = 5,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic [XLEN-1:0]   base_val,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   addr
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] addr_d;
  logic [XLEN-1:0] addr_q;

  always_comb begin
    base_eff = (base_sel == '0) ? '0 : base_val;
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    addr_d   = addr_q;
    if (load_en)      addr_d = base_eff + disp_ext;
    else if (step_en) addr_d = addr_q + XLEN'(STRIDE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  addr_q <= '0;
    else if (load_en || step_en) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int REG_COUNT = 32,
  parameter int IDX_W     = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [IDX_W-1:0] cmd_start_reg,
  input  logic             cmd_little_endian,
  input  logic             wr_ready,
  output logic             load_en,
  output logic             step_en,
  output logic [IDX_W-1:0] cur_reg,
  output logic             wr_valid,
  output logic             busy,
  output logic             done,
  output logic             fault
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_COUNT - 1);

  rbs_state_e       state_q, state_d;
  logic [IDX_W-1:0] reg_q, reg_d;
  logic             reg_en;

  always_comb begin
    state_d = state_q;
    reg_d   = reg_q;
    reg_en  = 1'b0;
    load_en = 1'b0;
    step_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (cmd_little_endian) begin
            state_d = ST_FAULT;
          end else begin
            state_d = ST_PUSH;
            reg_d   = cmd_start_reg;
            reg_en  = 1'b1;
            load_en = 1'b1;
          end
        end
      end
      ST_PUSH: begin
        if (wr_ready) begin
          if (reg_q == LAST_IDX) begin
            state_d = ST_FIN;
          end else begin
            reg_d   = reg_q + 1'b1;
            reg_en  = 1'b1;
            step_en = 1'b1;
          end
        end
      end
      ST_FIN:   state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_en) reg_q <= reg_d;
  end

  assign cur_reg  = reg_q;
  assign wr_valid = (state_q == ST_PUSH);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign fault    = (state_q == ST_FAULT);
endmodule

// File: rtl/reg_block_store_seq.sv
module reg_block_store_seq #(
  parameter int XLEN      = 64,
  parameter int WORD_W    = 32,
  parameter int DISP_W    = 16,
  parameter int REG_COUNT = 32,
  parameter int IDX_W     = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [IDX_W-1:0]  cmd_start_reg,
  input  logic [IDX_W-1:0]  cmd_base_sel,
  input  logic [XLEN-1:0]   cmd_base_val,
  input  logic [DISP_W-1:0] cmd_disp,
  input  logic              cmd_little_endian,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [WORD_W-1:0] rf_rd_data,
  output logic              mem_wvalid,
  output logic [XLEN-1:0]   mem_waddr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_wready,
  output logic              busy,
  output logic              done,
  output logic              align_exc
);
  localparam int STRIDE = WORD_W / 8;

  logic load_en;
  logic step_en;
  logic cmd_take;

  assign cmd_take = cmd_valid && !busy;

  rbs_ctrl #(
    .REG_COUNT (REG_COUNT),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmd_valid         (cmd_take),
    .cmd_start_reg     (cmd_start_reg),
    .cmd_little_endian (cmd_little_endian),
    .wr_ready          (mem_wready),
    .load_en           (load_en),
    .step_en           (step_en),
    .cur_reg           (rf_rd_idx),
    .wr_valid          (mem_wvalid),
    .busy              (busy),
    .done              (done),
    .fault             (align_exc)
  );

  rbs_addr_gen #(
    .XLEN   (XLEN),
    .DISP_W (DISP_W),
    .SEL_W  (IDX_W),
    .STRIDE (STRIDE)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .step_en  (step_en),
    .base_sel (cmd_base_sel),
    .base_val (cmd_base_val),
    .disp     (cmd_disp),
    .addr     (mem_waddr)
  );

  assign mem_wdata = rf_rd_data;
endmodule

// File: rtl/rbs_chk.sv
module rbs_chk #(
  parameter int XLEN      = 64,
  parameter int REG_COUNT = 32,
  parameter int IDX_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_little_endian,
  input logic [IDX_W-1:0] rf_rd_idx,
  input logic             mem_wvalid,
  input logic [XLEN-1:0]  mem_waddr,
  input logic             mem_wready,
  input logic             busy,
  input logic             done,
  input logic             align_exc
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_COUNT - 1);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(rf_rd_idx));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && mem_wready && rf_rd_idx != LAST_IDX |=>
      mem_wvalid && mem_waddr == $past(mem_waddr) + XLEN'(4) && rf_rd_idx == $past(rf_rd_idx) + 1'b1);

  // R6
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && mem_wready && rf_rd_idx == LAST_IDX |=> done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);

  // R7
  le_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_little_endian |=> align_exc && !mem_wvalid);

  // R7
  fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_exc |=> !busy && !align_exc);

  // R8
  take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy |=> busy);

  // R10
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wvalid, done, align_exc}));
endmodule

bind reg_block_store_seq rbs_chk #(
  .XLEN      (XLEN),
  .REG_COUNT (REG_COUNT),
  .IDX_W     (IDX_W)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cmd_valid         (cmd_valid),
  .cmd_little_endian (cmd_little_endian),
  .rf_rd_idx         (rf_rd_idx),
  .mem_wvalid        (mem_wvalid),
  .mem_waddr         (mem_waddr),
  .mem_wready        (mem_wready),
  .busy              (busy),
  .done              (done),
  .align_exc         (align_exc)
);

// File: tb/reg_block_store_seq_tb.sv
module reg_block_store_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int WDOG = 150000;

  logic            clk;
  logic            rst_n;
  logic            cmd_valid;
  logic [4:0]      cmd_start_reg;
  logic [4:0]      cmd_base_sel;
  logic [XLEN-1:0] cmd_base_val;
  logic [15:0]     cmd_disp;
  logic            cmd_little_endian;
  logic [4:0]      rf_rd_idx;
  logic [31:0]     rf_rd_data;
  logic            mem_wvalid;
  logic [XLEN-1:0] mem_waddr;
  logic [31:0]     mem_wdata;
  logic            mem_wready;
  logic            busy;
  logic            done;
  logic            align_exc;

  logic [63:0] rf [32];
  int n_run;
  int n_fail;
  int cyc;

  assign rf_rd_data = rf[rf_rd_idx][31:0];

  reg_block_store_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_start_reg(cmd_start_reg),
    .cmd_base_sel(cmd_base_sel), .cmd_base_val(cmd_base_val), .cmd_disp(cmd_disp),
    .cmd_little_endian(cmd_little_endian), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .mem_wvalid(mem_wvalid), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_wready(mem_wready), .busy(busy), .done(done), .align_exc(align_exc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [XLEN-1:0] ea_of(input logic [4:0] sel, input logic [XLEN-1:0] b,
                                             input logic [15:0] d);
    logic [XLEN-1:0] base;
    base = (sel == 5'd0) ? '0 : b;
    return base + {{(XLEN-16){d[15]}}, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill_rf();
    for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
  endtask

  task automatic run_store(input logic [4:0] s, input logic [4:0] sel, input logic [XLEN-1:0] b,
                           input logic [15:0] d, input int stall_pct, input bit junk);
    int n;
    int beats;
    int guard;
    bit rdy;
    logic [XLEN-1:0] ea;
    n = 32 - int'(s);
    ea = ea_of(sel, b, d);
    beats = 0;
    guard = 0;
    fill_rf();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_start_reg = s; cmd_base_sel = sel; cmd_base_val = b;
    cmd_disp = d; cmd_little_endian = 1'b0;
    @(negedge clk);
    if (junk) begin
      // R8: a different command while busy must not disturb the stream
      cmd_start_reg = 5'd3; cmd_base_sel = 5'd7; cmd_base_val = ~b; cmd_disp = ~d;
      cmd_little_endian = 1'b1;
    end else cmd_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", XLEN'(busy), 1);
    while (beats < n && guard < 4000) begin
      logic [4:0] er;
      er = 5'(int'(s) + beats);
      chk(mem_wvalid == 1'b1, "R2 write offered", XLEN'(mem_wvalid), 1);
      chk(rf_rd_idx == er, "R2 register order", XLEN'(rf_rd_idx), XLEN'(er));
      chk(mem_waddr == ea + XLEN'(4 * beats), beats == 0 ? "R1 first address" : "R4 address step",
          mem_waddr, ea + XLEN'(4 * beats));
      chk(mem_wdata == rf[er][31:0], "R3 write data", XLEN'(mem_wdata), XLEN'(rf[er][31:0]));
      rdy = (($urandom % 100) >= stall_pct);
      mem_wready = rdy;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (rdy) beats++;
      else chk(mem_wvalid == 1'b1, "R5 held under stall", XLEN'(mem_wvalid), 1);
      guard++;
    end
    mem_wready = 1'b0;
    chk(beats == n, "R2 word count", XLEN'(beats), XLEN'(n));
    chk(done == 1'b1 && mem_wvalid == 1'b0 && busy == 1'b1, "R6 done pulse",
        XLEN'({done, mem_wvalid, busy}), XLEN'(3'b101));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && mem_wvalid == 1'b0, "R6 idle after done",
        XLEN'({done, busy, mem_wvalid}), 0);
  endtask

  task automatic run_le(input logic [4:0] s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_start_reg = s; cmd_base_sel = 5'd1; cmd_base_val = 64'h1000;
    cmd_disp = 16'h0010; cmd_little_endian = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(align_exc == 1'b1 && mem_wvalid == 1'b0 && busy == 1'b1, "R7 exception pulse",
        XLEN'({align_exc, mem_wvalid, busy}), XLEN'(3'b101));
    @(negedge clk);
    chk(align_exc == 1'b0 && busy == 1'b0 && mem_wvalid == 1'b0, "R7 no write, idle",
        XLEN'({align_exc, busy, mem_wvalid}), 0);
    cmd_little_endian = 1'b0;
  endtask

  initial begin
    cyc = 0;
    while (cyc < WDOG) begin
      @(posedge clk);
      cyc++;
    end
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_start_reg = '0; cmd_base_sel = '0;
    cmd_base_val = '0; cmd_disp = '0; cmd_little_endian = 1'b0; mem_wready = 1'b0;
    fill_rf();
    repeat (3) @(negedge clk);
    chk(!busy && !mem_wvalid && !done && !align_exc, "R9 reset state",
        XLEN'({busy, mem_wvalid, done, align_exc}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_wvalid && !done && !align_exc, "R9 idle after reset",
        XLEN'({busy, mem_wvalid, done, align_exc}), 0);
    // R6: single word when starting at 31
    run_store(5'd31, 5'd4, 64'h0000_0000_0000_2000, 16'h0008, 0, 1'b0);
    // R1: zero base field ignores base value; full 32-word block
    run_store(5'd0, 5'd0, 64'hDEAD_BEEF_0000_0000, 16'h0100, 30, 1'b0);
    // R1: negative displacement
    run_store(5'd28, 5'd9, 64'h0000_0000_0001_0000, 16'hFFF0, 50, 1'b1);
    // R4: wrap across the top of the address space
    run_store(5'd26, 5'd2, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0000, 20, 1'b0);
    // R7: little-endian refusal
    run_le(5'd20);
    run_le(5'd31);
    for (int k = 0; k < 30; k++) begin
      run_store(5'($urandom % 32), 5'($urandom % 32), {$urandom, $urandom}, 16'($urandom),
                int'($urandom % 70), 1'($urandom));
      if (k % 10 == 5) run_le(5'($urandom % 32));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule